// File: doc/BRIEF.md
# Threshold Backtracking Sequential Decoder

This block decodes one zero-tail-terminated frame of an 8-state, rate 1/2 convolutional code. It does not keep a survivor for every trellis state. It walks a single path through the trellis, depth first. At each node it adds the Hamming mismatch of the chosen branch to a running tally. Any branch that would raise the tally to the threshold is pruned. When both branches at a node are pruned, the search backs up to the nearest earlier node that still has an untried branch.

Received hard-decision symbols arrive over a valid/ready stream, one two-bit symbol per transfer. The frame length and the threshold are sampled together with the first symbol of a frame. The block holds `sym_ready` high while it collects a frame. It drops `sym_ready` once the last symbol is taken and keeps it low for the whole search, so an upstream source simply stalls. A transfer happens on any rising clock edge where both `sym_valid` and `sym_ready` are high. The source may leave gaps between transfers. When the search ends, the block pulses `done` for one cycle with the decoded bits and a failure flag. It then reopens the input for the next frame.

Top module: `tbk_decoder`

## Requirements
- R1: After reset, `done`, `fail` and `dec_bits` are zero and `sym_ready` is high.
- R2: A frame takes exactly as many symbols as `frame_len` requests. A value of 0 counts as 1, and values above MAX_SYMS (16) count as MAX_SYMS. `frame_len` and `threshold` are captured only with the first symbol of the frame. `sym_ready` is low from the cycle after the last symbol until `done`, and is high again when `done` pulses.
- R3: The code uses a state (s1,s2,s3), with s1 the newest bit. With input u, the symbol is {v1,v2} where v1 = u^s1^s2^s3 and v2 = u^s1^s3. `sym_data[1]` carries v1 and `sym_data[0]` carries v2. The next state is (u,s1,s2), and the search starts in state 000.
- R4: At a free node, the branch with the smaller mismatch is tried first. When the mismatches are equal, input 0 is tried first.
- R5: A branch is rejected when the tally plus its mismatch is greater than or equal to `threshold`. A threshold of 0 rejects everything.
- R6: When both branches at a node are used up, the search returns to the previous depth and tries the untried branch there. With threshold 3, the frame 01 11 01 11 01 01 11 decodes to 1,0,1,1,0,0,0.
- R7: At the last three depths of a frame only input 0 is tried. If the frame is shorter than three symbols, every depth is restricted this way.
- R8: If the root node runs out of branches, the frame ends with `fail` high.
- R9: Each branch attempt or backtrack step counts one visit. If a frame has not reached full depth after MAX_VISITS visits, it ends with `fail` high.
- R10: `done` is a single-cycle pulse. Bit i of `dec_bits` is the decoded input at depth i, and bits at or above the frame length are 0. On failure, `dec_bits` is all zero. `fail` and `dec_bits` hold until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Received symbol present |
| sym_ready | output | 1 | Block can take a symbol |
| sym_data | input | 2 | Hard symbol {v1,v2} |
| frame_len | input | 5 | Symbols in the frame, tail included |
| threshold | input | 4 | Tally level at which a branch is rejected |
| done | output | 1 | One-cycle end-of-frame pulse |
| fail | output | 1 | Last frame was not decoded |
| dec_bits | output | 16 | Decoded bits, depth 0 in bit 0 |

## Verification
The hardest situation to reach from the ports is a deep backtrack that climbs two levels, exhausts a node that already had one branch accepted, and then succeeds along the other root branch. The stimulus gets there by feeding a frame with a single flipped bit in its first symbol and threshold 3. It also drives the visit budget both ways: a second instance with a budget of 12 visits sees clean frames of 12 and 13 symbols, and the same backtracking frame. The tie rule, the forced tail and a stale path from a longer earlier frame are each reached with short frames whose answers are worked out by hand.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

  localparam int TAIL_LEN = 3;

  typedef enum logic {
    PH_LOAD   = 1'b0,
    PH_SEARCH = 1'b1
  } phase_t;

  // st[2] = newest stored bit, st[0] = oldest
  function automatic logic [1:0] branch_word(input logic [2:0] st, input logic u);
    logic v1;
    logic v2;
    v1 = u ^ st[2] ^ st[1] ^ st[0];
    v2 = u ^ st[2] ^ st[0];
    return {v1, v2};
  endfunction

endpackage

// File: rtl/tbk_symbuf.sv
module tbk_symbuf #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       wr_sym,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_sym
);

  logic [1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot[g] <= 2'b00;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot[g] <= wr_sym;
      end
    end
  end

  assign rd_sym = slot[rd_idx];

endmodule

// File: rtl/tbk_branch_cost.sv
module tbk_branch_cost
  import tbk_pkg::*;
(
  input  logic [2:0] cur_state,
  input  logic [1:0] rx_sym,
  output logic [1:0] cost0,
  output logic [1:0] cost1,
  output logic       first_bit
);

  logic [1:0] diff0;
  logic [1:0] diff1;

  always_comb begin
    diff0     = branch_word(cur_state, 1'b0) ^ rx_sym;
    diff1     = branch_word(cur_state, 1'b1) ^ rx_sym;
    cost0     = {1'b0, diff0[1]} + {1'b0, diff0[0]};
    cost1     = {1'b0, diff1[1]} + {1'b0, diff1[0]};
    // strictly better input 1 goes first; ties favour input 0
    first_bit = (cost1 < cost0);
  end

endmodule

// File: rtl/tbk_search.sv
module tbk_search
  import tbk_pkg::*;
#(
  parameter int MAX_SYMS   = 16,
  parameter int TH_W       = 4,
  parameter int MAX_VISITS = 1024,
  localparam int DEP_W = $clog2(MAX_SYMS + 1),
  localparam int IDX_W = $clog2(MAX_SYMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DEP_W-1:0]    len,
  input  logic [TH_W-1:0]     thr,
  input  logic [1:0]          rx_sym,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                finish,
  output logic                found,
  output logic [MAX_SYMS-1:0] path_bits
);

  localparam int TAL_W = TH_W + 1;
  localparam int VIS_W = $clog2(MAX_VISITS + 1);

  logic                busy;
  logic [DEP_W-1:0]    depth;
  logic [VIS_W-1:0]    visits;
  logic [2:0]          st_q    [MAX_SYMS];
  logic [TAL_W-1:0]    tal_q   [MAX_SYMS];
  logic [1:0]          tried_q [MAX_SYMS];
  logic [MAX_SYMS-1:0] pick_q;

  logic [IDX_W-1:0] d_idx;
  logic [IDX_W-1:0] n_idx;
  logic [2:0]       cur_st;
  logic [TAL_W-1:0] cur_tal;
  logic [1:0]       cur_tried;
  logic [1:0]       cost0;
  logic [1:0]       cost1;
  logic             first_bit;
  logic             at_end;
  logic             out_of_budget;
  logic             forced;
  logic             exhausted;
  logic             try_bit;
  logic [1:0]       try_cost;
  logic [TAL_W-1:0] new_tal;
  logic             fits;
  logic [DEP_W:0]   reach;

  assign d_idx     = depth[IDX_W-1:0];
  assign n_idx     = d_idx + 1'b1;
  assign rd_idx    = d_idx;
  assign cur_st    = st_q[d_idx];
  assign cur_tal   = tal_q[d_idx];
  assign cur_tried = tried_q[d_idx];

  tbk_branch_cost u_cost (
    .cur_state (cur_st),
    .rx_sym    (rx_sym),
    .cost0     (cost0),
    .cost1     (cost1),
    .first_bit (first_bit)
  );

  always_comb begin
    reach         = {1'b0, depth} + (DEP_W + 1)'(TAIL_LEN);
    forced        = (reach >= {1'b0, len});
    at_end        = (depth == len);
    out_of_budget = (visits == VIS_W'(MAX_VISITS));
    exhausted     = forced ? (cur_tried >= 2'd1) : (cur_tried >= 2'd2);
    if (forced)                 try_bit = 1'b0;
    else if (cur_tried == 2'd0) try_bit = first_bit;
    else                        try_bit = ~first_bit;
    try_cost = try_bit ? cost1 : cost0;
    new_tal  = cur_tal + TAL_W'(try_cost);
    fits     = (new_tal < {1'b0, thr});
    finish   = busy && (at_end || out_of_budget || (exhausted && (depth == '0)));
    found    = busy && at_end;
  end

  // control: depth pointer and visit budget
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      depth  <= '0;
      visits <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      depth  <= '0;
      visits <= '0;
    end else if (busy) begin
      if (finish) begin
        busy <= 1'b0;
      end else begin
        visits <= visits + 1'b1;
        if (exhausted)  depth <= depth - 1'b1;
        else if (fits)  depth <= depth + 1'b1;
      end
    end
  end

  // node stack: state, tally and branch count per depth
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < MAX_SYMS; e++) begin
        st_q[e]    <= 3'b000;
        tal_q[e]   <= '0;
        tried_q[e] <= 2'd0;
      end
      pick_q <= '0;
    end else if (start) begin
      st_q[0]    <= 3'b000;
      tal_q[0]   <= '0;
      tried_q[0] <= 2'd0;
    end else if (busy && !finish && !exhausted) begin
      tried_q[d_idx] <= cur_tried + 2'd1;
      if (fits) begin
        pick_q[d_idx] <= try_bit;
        if (depth < DEP_W'(MAX_SYMS - 1)) begin
          st_q[n_idx]    <= {try_bit, cur_st[2:1]};
          tal_q[n_idx]   <= new_tal;
          tried_q[n_idx] <= 2'd0;
        end
      end
    end
  end

  for (genvar i = 0; i < MAX_SYMS; i++) begin : g_out
    assign path_bits[i] = (DEP_W'(i) < len) & pick_q[i];
  end

  // R5: every node entered below full depth carries a tally under the threshold
  a_r5_tally_under_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (depth != '0) && (depth < len)) |-> (tal_q[d_idx] < {1'b0, thr}));

  // R9: the visit count never passes the budget
  a_r9_budget_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (visits <= VIS_W'(MAX_VISITS)));

  // R7: a successful path ends with three zero inputs
  a_r7_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (found && (len >= DEP_W'(TAIL_LEN))) |-> ((path_bits >> (len - DEP_W'(TAIL_LEN))) == '0));

endmodule

// File: rtl/tbk_decoder.sv
module tbk_decoder
  import tbk_pkg::*;
#(
  parameter int MAX_SYMS   = 16,
  parameter int TH_W       = 4,
  parameter int MAX_VISITS = 1024,
  localparam int LEN_W = $clog2(MAX_SYMS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_valid,
  output logic                sym_ready,
  input  logic [1:0]          sym_data,
  input  logic [LEN_W-1:0]    frame_len,
  input  logic [TH_W-1:0]     threshold,
  output logic                done,
  output logic                fail,
  output logic [MAX_SYMS-1:0] dec_bits
);

  localparam int IDX_W = $clog2(MAX_SYMS);

  phase_t              phase;
  logic [LEN_W-1:0]    load_cnt;
  logic [LEN_W-1:0]    len_q;
  logic [TH_W-1:0]     thr_q;
  logic                start_q;
  logic                done_q;
  logic                fail_q;
  logic [MAX_SYMS-1:0] dec_q;

  logic [LEN_W-1:0]    eff_len;
  logic [LEN_W-1:0]    target;
  logic                take;
  logic                last;
  logic [IDX_W-1:0]    rd_idx;
  logic [1:0]          rd_sym;
  logic                finish;
  logic                found;
  logic [MAX_SYMS-1:0] path_bits;

  always_comb begin
    if (frame_len == '0)                       eff_len = LEN_W'(1);
    else if (frame_len > LEN_W'(MAX_SYMS))     eff_len = LEN_W'(MAX_SYMS);
    else                                       eff_len = frame_len;
    target    = (load_cnt == '0) ? eff_len : len_q;
    sym_ready = (phase == PH_LOAD);
    take      = sym_valid && sym_ready;
    last      = ((load_cnt + 1'b1) == target);
  end

  tbk_symbuf #(.DEPTH(MAX_SYMS)) u_buf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (take),
    .wr_idx (load_cnt[IDX_W-1:0]),
    .wr_sym (sym_data),
    .rd_idx (rd_idx),
    .rd_sym (rd_sym)
  );

  tbk_search #(
    .MAX_SYMS   (MAX_SYMS),
    .TH_W       (TH_W),
    .MAX_VISITS (MAX_VISITS)
  ) u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_q),
    .len       (len_q),
    .thr       (thr_q),
    .rx_sym    (rd_sym),
    .rd_idx    (rd_idx),
    .finish    (finish),
    .found     (found),
    .path_bits (path_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOAD;
      load_cnt <= '0;
      len_q    <= LEN_W'(1);
      thr_q    <= '0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
      dec_q    <= '0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      case (phase)
        PH_LOAD: begin
          if (take) begin
            if (load_cnt == '0) begin
              len_q <= eff_len;
              thr_q <= threshold;
            end
            load_cnt <= load_cnt + 1'b1;
            if (last) begin
              phase   <= PH_SEARCH;
              start_q <= 1'b1;
            end
          end
        end
        PH_SEARCH: begin
          if (finish) begin
            done_q   <= 1'b1;
            fail_q   <= ~found;
            dec_q    <= found ? path_bits : '0;
            phase    <= PH_LOAD;
            load_cnt <= '0;
          end
        end
        default: phase <= PH_LOAD;
      endcase
    end
  end

  assign done     = done_q;
  assign fail     = fail_q;
  assign dec_bits = dec_q;

  // R10: the completion strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a failed frame reports no bits
  a_r10_fail_clears_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (dec_bits == '0));

  // R2: input reopens together with the completion strobe
  a_r2_ready_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> sym_ready);

  // R8: the failure flag only changes at a completion strobe
  a_r8_fail_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> done);

endmodule

// File: tb/sim_tbk_decoder.sv
`timescale 1ns/1ps
module sim_tbk_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sym_valid = 1'b0;
  logic [1:0]  sym_data = 2'b00;
  logic [4:0]  frame_len = 5'd0;
  logic [3:0]  threshold = 4'd0;
  logic        rdy0, rdy1, done0, done1, fail0, fail1;
  logic [15:0] bits0, bits1;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [16:0] q0 [$];
  logic [16:0] q1 [$];
  string       t0 [$];
  string       t1 [$];
  logic [1:0]  fr [16];
  logic [15:0] clean_exp;

  always #2.5 clk = ~clk;

  tbk_decoder u0 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(rdy0),
    .sym_data(sym_data), .frame_len(frame_len), .threshold(threshold),
    .done(done0), .fail(fail0), .dec_bits(bits0)
  );

  tbk_decoder #(.MAX_VISITS(12)) u1 (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(rdy1),
    .sym_data(sym_data), .frame_len(frame_len), .threshold(threshold),
    .done(done1), .fail(fail1), .dec_bits(bits1)
  );

  function automatic logic [1:0] enc(input logic [2:0] s, input logic u);
    return {u ^ s[2] ^ s[1] ^ s[0], u ^ s[2] ^ s[0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // encode with the three-symbol zero tail applied
  task automatic build_clean(input logic [15:0] data, input int n);
    logic [2:0] st;
    logic u;
    st = 3'b000;
    clean_exp = '0;
    for (int i = 0; i < n; i++) begin
      u = (i + 3 < n) ? data[i] : 1'b0;
      fr[i] = enc(st, u);
      st = {u, st[2:1]};
      clean_exp[i] = u;
    end
  endtask

  // encode every bit as given, no tail
  task automatic build_raw(input logic [15:0] data, input int n);
    logic [2:0] st;
    st = 3'b000;
    for (int i = 0; i < n; i++) begin
      fr[i] = enc(st, data[i]);
      st = {data[i], st[2:1]};
    end
  endtask

  // driver: pushes expectations, then streams the frame
  task automatic send(input int n, input int flen, input int th,
                      input logic [15:0] e0b, input logic e0f,
                      input logic [15:0] e1b, input logic e1f,
                      input string tg0, input string tg1, input int gap);
    while (!(rdy0 && rdy1)) @(negedge clk);
    q0.push_back({e0f, e0b}); t0.push_back(tg0);
    q1.push_back({e1f, e1b}); t1.push_back(tg1);
    for (int i = 0; i < n; i++) begin
      sym_valid = 1'b1;
      sym_data  = fr[i];
      frame_len = (i == 0) ? 5'(flen) : 5'd1;   // R2: later values must be ignored
      threshold = (i == 0) ? 4'(th) : 4'd0;
      @(posedge clk);
      @(negedge clk);
      sym_valid = 1'b0;
      if (i < n - 1) repeat (gap) @(negedge clk);
    end
    check(rdy0 == 1'b0 && rdy1 == 1'b0, "R2 ready low during search", {rdy0, rdy1}, 0);
  endtask

  // monitor: compares each completion against the scoreboard
  always @(negedge clk) begin : mon
    logic [16:0] e;
    string tg;
    if (rst_n && done0) begin
      if (q0.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 u0 unexpected done actual=%h expected=none", {fail0, bits0});
      end else begin
        e = q0.pop_front(); tg = t0.pop_front();
        check({fail0, bits0} === e, {tg, " u0"}, {fail0, bits0}, e);
      end
    end
    if (rst_n && done1) begin
      if (q1.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 u1 unexpected done actual=%h expected=none", {fail1, bits1});
      end else begin
        e = q1.pop_front(); tg = t1.pop_front();
        check({fail1, bits1} === e, {tg, " u1"}, {fail1, bits1}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(done0 == 0 && fail0 == 0 && bits0 == 0 && rdy0 == 1, "R1 reset state",
          {done0, fail0, rdy0, bits0}, {3'b001, 16'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check(done0 == 0 && rdy0 == 1, "R1 idle after reset", {done0, rdy0}, 1);

    // R6 backtracking frame, one flipped bit in the first symbol
    fr[0] = 2'b01; fr[1] = 2'b11; fr[2] = 2'b01; fr[3] = 2'b11;
    fr[4] = 2'b01; fr[5] = 2'b01; fr[6] = 2'b11;
    send(7, 7, 3, 16'h000D, 1'b0, 16'h0000, 1'b1, "R6 backtrack", "R9 budget on backtrack", 0);
    // R8 same frame, threshold 1: root exhausted
    send(7, 7, 1, 16'h0, 1'b1, 16'h0, 1'b1, "R8 root exhausted", "R8 root exhausted", 1);
    // R5 threshold 0 rejects a clean frame
    build_clean(16'h000D, 7);
    send(7, 7, 0, 16'h0, 1'b1, 16'h0, 1'b1, "R5 zero threshold", "R5 zero threshold", 0);
    // R4 tie at root with 01, threshold 2 boundary accepts
    fr[0] = 2'b01; fr[1] = 2'b00; fr[2] = 2'b00; fr[3] = 2'b00;
    send(4, 4, 2, 16'h0, 1'b0, 16'h0, 1'b0, "R4 tie picks zero", "R4 tie picks zero", 0);
    // R5 same frame at threshold 1 is rejected
    send(4, 4, 1, 16'h0, 1'b1, 16'h0, 1'b1, "R5 tally equal threshold", "R5 tally equal threshold", 2);
    // R4 tie with symbol 10
    fr[0] = 2'b10;
    send(4, 4, 15, 16'h0, 1'b0, 16'h0, 1'b0, "R4 tie 10", "R4 tie 10", 0);
    // R7 tail forced to zero despite an all-ones stream
    build_raw(16'h007F, 7);
    send(7, 7, 15, 16'h000F, 1'b0, 16'h000F, 1'b0, "R7 forced tail", "R7 forced tail", 0);
    // R3 clean full-length frame, gaps in the stream
    build_clean(16'hA5B3, 16);
    send(16, 16, 3, clean_exp, 1'b0, 16'h0, 1'b1, "R3 clean 16", "R9 budget 16", 2);
    // R9 boundary: 12 visits suffice for 12 symbols, not for 13
    build_clean(16'h0F3C, 12);
    send(12, 12, 2, clean_exp, 1'b0, clean_exp, 1'b0, "R3 clean 12", "R9 budget exact", 0);
    build_clean(16'h1234, 13);
    send(13, 13, 3, clean_exp, 1'b0, 16'h0, 1'b1, "R3 clean 13", "R9 budget over", 1);
    // R7 single-symbol frame, only input 0 allowed
    fr[0] = 2'b11;
    send(1, 1, 3, 16'h0, 1'b0, 16'h0, 1'b0, "R7 short frame", "R7 short frame", 0);
    // R2 length 0 counts as one symbol
    fr[0] = 2'b00;
    send(1, 0, 3, 16'h0, 1'b0, 16'h0, 1'b0, "R2 zero length", "R2 zero length", 0);
    // R2 length above 16 clamps
    build_clean(16'hFFFF, 16);
    send(16, 20, 15, clean_exp, 1'b0, 16'h0, 1'b1, "R2 clamp length", "R9 budget clamp", 1);
    // R10 short frame after a long one: stale upper bits must read zero
    build_clean(16'h0001, 4);
    send(4, 4, 3, 16'h0001, 1'b0, 16'h0001, 1'b0, "R10 upper bits zero", "R10 upper bits zero", 0);

    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    check(fail0 == 0 && bits0 == 16'h0001, "R10 result held", {fail0, bits0}, 16'h0001);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule